// File: doc/BRIEF.md
# Write-only I2C command receiver

This block is an I2C target that only accepts writes, at one fixed 7-bit address. A bus master opens a transfer with START and sends the address byte with the direction bit cleared. The master then sends any number of command bytes and closes with STOP. Every command byte carries its own selector, so the receiver keeps no sub-address and no register pointer. It delivers each byte on a parallel output with a one-cycle strobe. Logic downstream decodes the byte.

SCL and SDA are sampled by a much faster system clock: at least 16 times the bit rate, for a bus of up to 100 kbit/s. Each line goes through a synchronizer and a glitch filter before START, STOP and clock edges are detected. The acknowledge is produced as an enable that pulls the open-drain SDA line low. After an address that does not match, or a read request, the receiver stays silent until the next START.

Top module: `i2c_cmd_rx`

## Requirements
- R1: While reset is high and in the first cycle after reset, `sda_oe` and `byte_valid` are 0.
- R2: A falling SDA while SCL is high is START and begins address reception. A rising SDA while SCL is high is STOP and returns the receiver to idle.
- R3: Bits are sampled on rising SCL, most significant bit first. The first bit sampled after the address ends up in `byte_data[7]`.
- R4: The address byte 8'h88 is acknowledged. This is 7-bit address 7'h44 with the direction bit (bit 0) at 0. To acknowledge, `sda_oe` is 1 while SCL is high during the ninth clock.
- R5: After a matching address, every data byte is acknowledged in its ninth clock.
- R6: Any other address with bit 0 at 0 gets no acknowledge. Until the next START there is neither an acknowledge nor a strobe.
- R7: An address byte with bit 0 at 1 (a read request, for example 8'h89) gets no acknowledge, and the following bytes get neither an acknowledge nor a strobe.
- R8: Each data byte gives exactly one `byte_valid` pulse, one system clock wide. The pulse comes after its eighth bit. The address byte never gives a pulse.
- R9: `sda_oe` is 0 while SCL is high during any of the eight bit clocks. It is released after the falling SCL edge that ends the ninth clock.
- R10: A STOP in the middle of a byte discards the partial byte: no strobe follows, and `sda_oe` stays 0.
- R11: A repeated START, with no STOP before it, restarts address reception. This holds both after an accepted transfer and after an ignored one.
- R12: A pulse on SCL shorter than the filter length (3 system clocks by default) is not seen as a clock edge and does not corrupt the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| byte_valid | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | 8 | Received data byte, valid with the strobe |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that every legal level on either line lasts well beyond the filter length, so that each bus event reaches the receiver as one clean edge. The stimulus holds each quarter of the bus bit for ten system clocks and moves SDA only in the middle of the SCL low phase. The only pulse shorter than the filter is the single SCL glitch injected on purpose. The bus is modelled as open drain: the master's level is ANDed with the inverse of `sda_oe`. The acknowledge therefore appears on the same wire that the master reads.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 2);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   out_q;
  logic                   settled;

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign settled = sync_q[SYNC_STAGES-1];

  // A new level is taken only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (settled != out_q) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        out_q <= settled;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign line_o = out_q;

  generate
    if (FILT_LEN > 1) begin : g_hold_chk
      // R12: a filtered level always lasts at least two cycles
      assert_filter_holds_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q) |=> $stable(out_q));
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise   = !scl_q && scl_f;
  assign scl_fall   = scl_q && !scl_f;
  assign start_cond = scl_q && scl_f && sda_q && !sda_f;
  assign stop_cond  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_cond,
  input  logic              stop_cond,
  input  logic              sda_f,
  output logic              sda_oe,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
  localparam logic [BITCNT_W-1:0] ACK_WAIT = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] ACK_HOLD = BITCNT_W'(BYTE_W + 1);
  localparam logic [BYTE_W-1:0]   WR_ADDR  = {ADDR7, 1'b0};

  rx_state_t           state;
  logic [BITCNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   next_byte;
  logic                addr_ok;
  logic                receiving;

  assign next_byte = {shreg[BYTE_W-2:0], sda_f};
  assign receiving = (state == RX_ADDR) || (state == RX_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      addr_ok    <= 1'b0;
      sda_oe     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (start_cond) begin
        state  <= RX_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_cond) begin
        state  <= RX_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && bitcnt < ACK_WAIT) begin
          shreg  <= next_byte;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            if (state == RX_DATA) begin
              byte_valid <= 1'b1;
              byte_data  <= next_byte;
            end else begin
              addr_ok <= (next_byte == WR_ADDR);
            end
          end
        end else if (scl_fall && bitcnt == ACK_WAIT) begin
          if (state == RX_ADDR && !addr_ok) begin
            state  <= RX_SKIP;
            bitcnt <= '0;
          end else begin
            sda_oe <= 1'b1;
            bitcnt <= ACK_HOLD;
          end
        end else if (scl_fall && bitcnt == ACK_HOLD) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          state  <= RX_DATA;
        end
      end
    end
  end

  // R4: the acknowledge pull starts only right after a falling SCL
  assert_ack_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R9: the pull is released only on a falling SCL or a bus condition
  assert_release_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> $past(scl_fall || start_cond || stop_cond));
  // R6: an ignored transfer neither pulls the line nor strobes
  assert_skip_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (state == RX_SKIP) |-> (!sda_oe && !byte_valid));
  // R8: the strobe is one cycle wide
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  // R10: after STOP the line is released and nothing is delivered
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    stop_cond |=> (!sda_oe && !byte_valid));
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h44,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic scl_rise, scl_fall, start_cond, stop_cond;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (filt_lines[1]),
    .sda_f     (filt_lines[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_cond(start_cond),
    .stop_cond (stop_cond)
  );

  i2c_rx_engine #(
    .ADDR7(ADDR7)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_cond(start_cond),
    .stop_cond (stop_cond),
    .sda_f     (filt_lines[0]),
    .sda_oe    (sda_oe),
    .byte_valid(byte_valid),
    .byte_data (byte_data)
  );
endmodule

// File: tb/i2c_cmd_rx_tb.sv
module i2c_cmd_rx_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, byte_valid;
  logic [7:0] byte_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit prev_bv = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_cmd_rx u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .byte_valid(byte_valid),
    .byte_data (byte_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: every strobe must match the next expected byte.
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R8", "unexpected strobe", byte_data, 0);
        end else begin
          chk(byte_data == exp_q[0], "R3", "byte value", byte_data, exp_q[0]);
          chk(!prev_bv, "R8", "strobe width", 2, 1);
          void'(exp_q.pop_front());
        end
      end
      prev_bv = byte_valid;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input bit exp_strobe, input bit glitch,
                           input string req);
    bit oe_seen = 1'b0;
    if (exp_strobe) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(Q);
      if (sda_oe) oe_seen = 1'b1;
      if (glitch && i == 4) begin
        m_scl = 1'b0; wq(1);
        m_scl = 1'b1; wq(Q - 1);
      end else begin
        wq(Q);
      end
      m_scl = 1'b0; wq(Q);
    end
    chk(!oe_seen, "R9", "pull during bit clock", oe_seen, 0);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    chk((!sda_line) == exp_ack, req, "acknowledge", !sda_line, exp_ack);
    wq(Q);
    m_scl = 1'b0; wq(Q);
    chk(!sda_oe, "R9", "release after ninth clock", sda_oe, 0);
  endtask

  task automatic chk_drained(input string req);
    wq(4);
    chk(exp_q.size() == 0, req, "bytes outstanding", exp_q.size(), 0);
  endtask

  initial begin
    wq(3);
    chk(!sda_oe && !byte_valid, "R1", "outputs in reset", {sda_oe, byte_valid}, 0);
    rst = 1'b0;
    wq(1);
    chk(!sda_oe && !byte_valid, "R1", "outputs after reset", {sda_oe, byte_valid}, 0);
    wq(Q);

    // R2 R4 R5: matching write with three command bytes
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R4");
    send_byte(8'hA5, 1'b1, 1'b1, 1'b0, "R5");
    send_byte(8'h3C, 1'b1, 1'b1, 1'b0, "R5");
    send_byte(8'h01, 1'b1, 1'b1, 1'b0, "R5");
    bus_stop();
    chk_drained("R2");

    // R6: wrong address is ignored
    bus_start();
    send_byte(8'h90, 1'b0, 1'b0, 1'b0, "R6");
    send_byte(8'h11, 1'b0, 1'b0, 1'b0, "R6");
    send_byte(8'h88, 1'b0, 1'b0, 1'b0, "R6");
    bus_stop();
    chk_drained("R6");

    // R7: read request is ignored
    bus_start();
    send_byte(8'h89, 1'b0, 1'b0, 1'b0, "R7");
    send_byte(8'h5A, 1'b0, 1'b0, 1'b0, "R7");
    bus_stop();
    chk_drained("R7");

    // R11: repeated start after accepted and after ignored transfers
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R11");
    send_byte(8'h55, 1'b1, 1'b1, 1'b0, "R11");
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R11");
    send_byte(8'hF0, 1'b1, 1'b1, 1'b0, "R11");
    bus_start();
    send_byte(8'h22, 1'b0, 1'b0, 1'b0, "R11");
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R11");
    send_byte(8'h7E, 1'b1, 1'b1, 1'b0, "R11");
    bus_stop();
    chk_drained("R11");

    // R10: stop in the middle of a data byte
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
    end
    bus_stop();
    chk(!sda_oe, "R10", "line after early stop", sda_oe, 0);
    chk_drained("R10");
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R10");
    send_byte(8'h12, 1'b1, 1'b1, 1'b0, "R10");
    bus_stop();
    chk_drained("R10");

    // R12: short SCL glitch in the middle of a data bit
    bus_start();
    send_byte(8'h88, 1'b1, 1'b0, 1'b0, "R12");
    send_byte(8'hC3, 1'b1, 1'b1, 1'b1, "R12");
    send_byte(8'h96, 1'b1, 1'b1, 1'b1, "R12");
    bus_stop();
    chk_drained("R12");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule